// File: doc/BRIEF.md
# Hub configuration boot loader

After reset this block works out which set of hub configuration parameters the hub will use. Two serial configuration memories can be attached. Each is reached through a simple byte-read request/response port with a presence flag. The loader tries the primary memory first, then the secondary memory. If neither yields a usable image, it uses built-in defaults modified by strap inputs. A reduced-pin strap removes the primary memory from the search and also disables the strap adjustments.

An image is accepted only if its check byte equals the 8-bit sum of the four ID bytes plus one. From an accepted image the loader takes the vendor and product IDs, the fixed-port mask, the active-port count and the maximum-power byte. It then presents decoded values: per-port fixed flags, a port count with an active-port bit vector, and the power value doubled. Once loading is complete, a done flag rises and stays high. A source code reports which of the three origins supplied the values.

Top module: `hub_cfg_loader`

## Requirements
- R1: The primary memory (port rom0) is probed first. The secondary memory (rom1) is probed only after the primary has failed, and the defaults are used only after both have failed. `src_o` reads 0 for primary, 1 for secondary and 2 for defaults, and never more than one memory request is high at a time.
- R2: While `reduced_pin_i` is high, rom0 is never requested and the probe starts at rom1. In that mode the strap inputs are ignored, and the defaults are used unchanged.
- R3: A probe reads addresses 00h–04h, 06h, 07h and 08h, each exactly once and in that order. The vendor ID is {byte 01h, byte 00h} and the product ID is {byte 03h, byte 02h}.
- R4: An image is valid only when byte 04h equals (byte00h + byte01h + byte02h + byte03h + 1) mod 256. An invalid image is discarded, and the next source is tried.
- R5: For an accepted image, `fixed_ports_o[k]` equals bit k+1 of byte 06h (k = 0..3), where 1 means the port is fixed. Bits 0, 5, 6 and 7 of byte 06h have no effect.
- R6: A count byte y in 1..4 gives `port_count_o` = y and `active_ports_o` with bits 0..y-1 set. Any other value gives a count of 4 with `count_clamped_o` = 1. When the count is not clamped, `count_clamped_o` = 0.
- R7: `max_power_o` equals 2 × byte 08h as a 9-bit value.
- R8: The defaults are vendor 04B4h, product 6570h and a power byte of 32h (`max_power_o` = 100). The fixed-port bits come from `strap_fixed_i`, with bit k for port k+1. The port count is 4 − `strap_count_i`, so strap 3 gives 1 port and strap 0 gives 4 ports.
- R9: A memory whose presence flag is low is skipped without any request being issued.
- R10: A byte request held high for `TIMEOUT_CYCLES` cycles without an acknowledge abandons that memory, which is treated as absent.
- R11: After reset, `done_o` is 0 and all configuration outputs are 0. `done_o` rises exactly once, and all outputs stay stable from the cycle it rises until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reduced_pin_i | input | 1 | Reduced-pin variant: skip rom0, ignore straps |
| strap_fixed_i | input | 4 | Strap fixed-port flags, bit k = port k+1 |
| strap_count_i | input | 2 | Strap port-count code, count = 4 − code |
| rom0_present_i | input | 1 | Primary memory presence |
| rom0_req_o | output | 1 | Primary byte-read request |
| rom0_addr_o | output | ADDR_W | Primary byte address |
| rom0_ack_i | input | 1 | Primary response valid |
| rom0_data_i | input | 8 | Primary response byte |
| rom1_present_i | input | 1 | Secondary memory presence |
| rom1_req_o | output | 1 | Secondary byte-read request |
| rom1_addr_o | output | ADDR_W | Secondary byte address |
| rom1_ack_i | input | 1 | Secondary response valid |
| rom1_data_i | input | 8 | Secondary response byte |
| vid_o | output | 16 | Vendor ID |
| pid_o | output | 16 | Product ID |
| fixed_ports_o | output | 4 | Per-port fixed flags |
| port_count_o | output | 3 | Active-port count |
| active_ports_o | output | 4 | Active ports 1..count as bits 0..count-1 |
| max_power_o | output | 9 | Reported maximum power (2 × byte) |
| count_clamped_o | output | 1 | Count byte out of range and clamped |
| src_o | output | 2 | Selected source |
| done_o | output | 1 | Loading complete |

## Verification
The bench builds the loader with `TIMEOUT_CYCLES` = 6. This lets a silent memory expire its per-byte timeout within a few cycles, so each abandon-and-fall-back path can be run hundreds of times. It also lets the bench check that the observed run length of an unanswered request equals exactly 6. With that short run length, the bench can afford complete sweeps of the check byte, the fixed-mask byte and the power byte (256 values each), every count byte from 0 to 15 plus FFh, and all 64 strap combinations. Memory latency varies from case to case, so the handshake is exercised at several response delays.

// File: rtl/hub_cfg_pkg.sv
package hub_cfg_pkg;
  localparam int NUM_PORTS = 4;
  localparam int CNT_W     = $clog2(NUM_PORTS + 1);
  localparam int SEL_W     = $clog2(NUM_PORTS);
  localparam int IMG_BYTES = 8;
  localparam int SKIP_IDX  = 5;

  localparam logic [15:0] DEF_VID   = 16'h04B4;
  localparam logic [15:0] DEF_PID   = 16'h6570;
  localparam logic [7:0]  DEF_POWER = 8'h32;

  typedef enum logic [1:0] {
    SRC_PRIMARY   = 2'd0,
    SRC_SECONDARY = 2'd1,
    SRC_STRAPS    = 2'd2
  } cfg_src_e;

  typedef struct packed {
    logic [15:0]          vid;
    logic [15:0]          pid;
    logic [NUM_PORTS-1:0] fixed;
    logic [CNT_W-1:0]     count;
    logic [8:0]           power;
    logic                 clamped;
  } hub_cfg_t;
endpackage

// File: rtl/cfg_byte_reader.sv
module cfg_byte_reader
  import hub_cfg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int ADDR_W         = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   present_i,
  output logic                   req_o,
  output logic [ADDR_W-1:0]      addr_o,
  input  logic                   ack_i,
  input  logic [7:0]             data_i,
  output logic                   done_o,
  output logic                   ok_o,
  output logic [IMG_BYTES*8-1:0] img_o
);
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int IDX_W = $clog2(IMG_BYTES);

  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_END} rd_state_e;

  rd_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TMR_W-1:0] tmr_q;
  logic             ok_q;
  logic [7:0]       img_q [IMG_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      case (state_q)
        RD_IDLE: if (start_i) begin
          idx_q <= '0;
          tmr_q <= '0;
          ok_q  <= 1'b0;
          state_q <= present_i ? RD_REQ : RD_END;
        end
        RD_REQ: begin
          if (ack_i) begin
            tmr_q <= '0;
            if (idx_q == IDX_W'(IMG_BYTES - 1)) begin
              ok_q    <= 1'b1;
              state_q <= RD_END;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else if (tmr_q == TMR_W'(TIMEOUT_CYCLES - 1)) begin
            ok_q    <= 1'b0;
            state_q <= RD_END;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (state_q == RD_REQ && ack_i) img_q[idx_q] <= data_i;
  end

  for (genvar b = 0; b < IMG_BYTES; b++) begin : g_flat
    assign img_o[b*8 +: 8] = img_q[b];
  end

  // byte 05h is reserved and never fetched
  assign addr_o = (idx_q < IDX_W'(SKIP_IDX)) ? ADDR_W'(idx_q) : ADDR_W'(idx_q) + 1'b1;
  assign req_o  = (state_q == RD_REQ);
  assign done_o = (state_q == RD_END);
  assign ok_o   = ok_q;

  AST_RD_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (tmr_q < TMR_W'(TIMEOUT_CYCLES))); // R10
  AST_RD_ABSENT_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_IDLE && start_i && !present_i) |=> (!req_o && done_o && !ok_o)); // R9
  AST_RD_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (!req_o || $stable(addr_o))); // R3
endmodule

// File: rtl/cfg_image_decode.sv
module cfg_image_decode
  import hub_cfg_pkg::*;
(
  input  logic [IMG_BYTES*8-1:0] img_i,
  output logic                   valid_o,
  output hub_cfg_t               cfg_o
);
  logic [7:0] b [IMG_BYTES];
  logic [7:0] sum;
  logic       in_range;

  for (genvar i = 0; i < IMG_BYTES; i++) begin : g_split
    assign b[i] = img_i[i*8 +: 8];
  end

  assign sum      = b[0] + b[1] + b[2] + b[3] + 8'd1;
  assign valid_o  = (sum == b[4]);
  assign in_range = (b[6] >= 8'd1) && (b[6] <= 8'(NUM_PORTS));

  always_comb begin
    cfg_o.vid     = {b[1], b[0]};
    cfg_o.pid     = {b[3], b[2]};
    cfg_o.fixed   = b[5][NUM_PORTS:1];
    cfg_o.count   = in_range ? b[6][CNT_W-1:0] : CNT_W'(NUM_PORTS);
    cfg_o.clamped = !in_range;
    cfg_o.power   = {b[7], 1'b0};
  end
endmodule

// File: rtl/cfg_strap_defaults.sv
module cfg_strap_defaults
  import hub_cfg_pkg::*;
(
  input  logic                 reduced_i,
  input  logic [NUM_PORTS-1:0] fixed_i,
  input  logic [SEL_W-1:0]     count_i,
  output hub_cfg_t             cfg_o
);
  always_comb begin
    cfg_o.vid     = DEF_VID;
    cfg_o.pid     = DEF_PID;
    cfg_o.power   = {DEF_POWER, 1'b0};
    cfg_o.clamped = 1'b0;
    if (reduced_i) begin
      cfg_o.fixed = '0;
      cfg_o.count = CNT_W'(NUM_PORTS);
    end else begin
      cfg_o.fixed = fixed_i;
      cfg_o.count = CNT_W'(NUM_PORTS) - CNT_W'(count_i);
    end
  end
endmodule

// File: rtl/hub_cfg_loader.sv
module hub_cfg_loader
  import hub_cfg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int ADDR_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reduced_pin_i,
  input  logic [3:0]        strap_fixed_i,
  input  logic [1:0]        strap_count_i,
  input  logic              rom0_present_i,
  output logic              rom0_req_o,
  output logic [ADDR_W-1:0] rom0_addr_o,
  input  logic              rom0_ack_i,
  input  logic [7:0]        rom0_data_i,
  input  logic              rom1_present_i,
  output logic              rom1_req_o,
  output logic [ADDR_W-1:0] rom1_addr_o,
  input  logic              rom1_ack_i,
  input  logic [7:0]        rom1_data_i,
  output logic [15:0]       vid_o,
  output logic [15:0]       pid_o,
  output logic [3:0]        fixed_ports_o,
  output logic [2:0]        port_count_o,
  output logic [3:0]        active_ports_o,
  output logic [8:0]        max_power_o,
  output logic              count_clamped_o,
  output logic [1:0]        src_o,
  output logic              done_o
);
  localparam int NSRC = 2;

  typedef enum logic [2:0] {
    T_BOOT, T_P0_GO, T_P0_WAIT, T_P1_GO, T_P1_WAIT, T_FINISH
  } top_state_e;

  top_state_e             state_q;
  hub_cfg_t               cfg_q;
  cfg_src_e               src_q;
  logic                   done_q;

  logic [NSRC-1:0]        rd_start, rd_present, rd_req, rd_ack, rd_done, rd_ok, rd_valid;
  logic [ADDR_W-1:0]      rd_addr [NSRC];
  logic [7:0]             rd_data [NSRC];
  logic [IMG_BYTES*8-1:0] rd_img  [NSRC];
  hub_cfg_t               rd_cfg  [NSRC];
  hub_cfg_t               def_cfg;

  assign rd_present = {rom1_present_i, rom0_present_i};
  assign rd_ack     = {rom1_ack_i, rom0_ack_i};
  assign rd_data[0] = rom0_data_i;
  assign rd_data[1] = rom1_data_i;
  assign rd_start   = {state_q == T_P1_GO, state_q == T_P0_GO};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    cfg_byte_reader #(
      .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
      .ADDR_W        (ADDR_W)
    ) u_reader (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (rd_start[i]),
      .present_i(rd_present[i]),
      .req_o    (rd_req[i]),
      .addr_o   (rd_addr[i]),
      .ack_i    (rd_ack[i]),
      .data_i   (rd_data[i]),
      .done_o   (rd_done[i]),
      .ok_o     (rd_ok[i]),
      .img_o    (rd_img[i])
    );
    cfg_image_decode u_decode (
      .img_i  (rd_img[i]),
      .valid_o(rd_valid[i]),
      .cfg_o  (rd_cfg[i])
    );
  end

  cfg_strap_defaults u_defaults (
    .reduced_i(reduced_pin_i),
    .fixed_i  (strap_fixed_i),
    .count_i  (strap_count_i),
    .cfg_o    (def_cfg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= T_BOOT;
      cfg_q   <= '0;
      src_q   <= SRC_PRIMARY;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        T_BOOT:  state_q <= reduced_pin_i ? T_P1_GO : T_P0_GO;
        T_P0_GO: state_q <= T_P0_WAIT;
        T_P0_WAIT: if (rd_done[0]) begin
          if (rd_ok[0] && rd_valid[0]) begin
            cfg_q   <= rd_cfg[0];
            src_q   <= SRC_PRIMARY;
            done_q  <= 1'b1;
            state_q <= T_FINISH;
          end else begin
            state_q <= T_P1_GO;
          end
        end
        T_P1_GO: state_q <= T_P1_WAIT;
        T_P1_WAIT: if (rd_done[1]) begin
          if (rd_ok[1] && rd_valid[1]) begin
            cfg_q <= rd_cfg[1];
            src_q <= SRC_SECONDARY;
          end else begin
            cfg_q <= def_cfg;
            src_q <= SRC_STRAPS;
          end
          done_q  <= 1'b1;
          state_q <= T_FINISH;
        end
        default: state_q <= T_FINISH;
      endcase
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_PORTS; k++) active_ports_o[k] = (CNT_W'(k) < cfg_q.count);
  end

  assign rom0_req_o      = rd_req[0];
  assign rom1_req_o      = rd_req[1];
  assign rom0_addr_o     = rd_addr[0];
  assign rom1_addr_o     = rd_addr[1];
  assign vid_o           = cfg_q.vid;
  assign pid_o           = cfg_q.pid;
  assign fixed_ports_o   = cfg_q.fixed;
  assign port_count_o    = cfg_q.count;
  assign max_power_o     = cfg_q.power;
  assign count_clamped_o = cfg_q.clamped;
  assign src_o           = src_q;
  assign done_o          = done_q;

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(cfg_q) && $stable(src_q))); // R11
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_req)); // R1
  AST_REDUCED_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reduced_pin_i |-> !rd_req[0]); // R2
  AST_COUNT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (port_count_o >= 3'd1 && port_count_o <= 3'(NUM_PORTS))); // R6
  AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rd_req == '0)); // R1
endmodule

// File: tb/hub_cfg_loader_tb.sv
module hub_cfg_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       reduced = 1'b0;
  logic [3:0] sfix = '0;
  logic [1:0] ssel = '0;
  logic       pres0 = 1'b0, pres1 = 1'b0, mute0 = 1'b0, mute1 = 1'b0;
  int         lat0 = 1, lat1 = 1;
  logic [7:0] img0 [16];
  logic [7:0] img1 [16];

  logic       req0, req1, ack0, ack1;
  logic [7:0] addr0, addr1, dat0, dat1;
  logic [15:0] vid, pid;
  logic [3:0]  fixed, active;
  logic [2:0]  count;
  logic [8:0]  power;
  logic        clamped, done;
  logic [1:0]  src;

  hub_cfg_loader #(.TIMEOUT_CYCLES(TMO), .ADDR_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reduced_pin_i(reduced),
    .strap_fixed_i(sfix), .strap_count_i(ssel),
    .rom0_present_i(pres0), .rom0_req_o(req0), .rom0_addr_o(addr0),
    .rom0_ack_i(ack0), .rom0_data_i(dat0),
    .rom1_present_i(pres1), .rom1_req_o(req1), .rom1_addr_o(addr1),
    .rom1_ack_i(ack1), .rom1_data_i(dat1),
    .vid_o(vid), .pid_o(pid), .fixed_ports_o(fixed), .port_count_o(count),
    .active_ports_o(active), .max_power_o(power), .count_clamped_o(clamped),
    .src_o(src), .done_o(done)
  );

  // memory models and monitors
  int   cnt0, cnt1, run0, run1, max0, max1, rises;
  logic [15:0] seen0, seen1;
  logic req1_ever, order_bad, dup_bad, done_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      ack0 <= 0; cnt0 <= 0; run0 <= 0; max0 <= 0; seen0 <= '0; dat0 <= '0;
      ack1 <= 0; cnt1 <= 0; run1 <= 0; max1 <= 0; seen1 <= '0; dat1 <= '0;
      req1_ever <= 0; order_bad <= 0; dup_bad <= 0; rises <= 0; done_d <= 0;
    end else begin
      done_d <= done;
      if (done && !done_d) rises <= rises + 1;
      if (req1) req1_ever <= 1;
      if (req0 && req1_ever) order_bad <= 1;
      if (req0 && pres0 && !mute0 && !ack0) begin
        if (cnt0 >= lat0) begin
          ack0 <= 1; dat0 <= img0[addr0[3:0]]; cnt0 <= 0;
          if (seen0[addr0[3:0]] || (addr0[3:0] != 0 && !seen0[addr0[3:0] == 4'd6 ? 4 : addr0[3:0]-1])) dup_bad <= 1;
          seen0[addr0[3:0]] <= 1;
        end else cnt0 <= cnt0 + 1;
      end else begin ack0 <= 0; cnt0 <= 0; end
      if (req1 && pres1 && !mute1 && !ack1) begin
        if (cnt1 >= lat1) begin
          ack1 <= 1; dat1 <= img1[addr1[3:0]]; cnt1 <= 0;
          seen1[addr1[3:0]] <= 1;
        end else cnt1 <= cnt1 + 1;
      end else begin ack1 <= 0; cnt1 <= 0; end
      if (req0 && !ack0) begin run0 <= run0 + 1; if (run0 + 1 > max0) max0 <= run0 + 1; end
      else run0 <= 0;
      if (req1 && !ack1) begin run1 <= run1 + 1; if (run1 + 1 > max1) max1 <= run1 + 1; end
      else run1 <= 0;
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_img(input bit which, input logic [15:0] v, input logic [15:0] p,
                         input logic [7:0] m, input logic [7:0] c, input logic [7:0] w);
    logic [7:0] t [16];
    for (int i = 0; i < 16; i++) t[i] = 8'hFF;
    t[0] = v[7:0]; t[1] = v[15:8]; t[2] = p[7:0]; t[3] = p[15:8];
    t[4] = t[0] + t[1] + t[2] + t[3] + 8'd1;
    t[5] = 8'hFE; t[6] = m; t[7] = c; t[8] = w;
    for (int i = 0; i < 16; i++) if (which) img1[i] = t[i]; else img0[i] = t[i];
  endtask

  function automatic bit img_ok(input bit which);
    logic [7:0] s;
    if (which) begin
      s = img1[0] + img1[1] + img1[2] + img1[3] + 8'd1;
      return pres1 && !mute1 && (s == img1[4]);
    end
    s = img0[0] + img0[1] + img0[2] + img0[3] + 8'd1;
    return pres0 && !mute0 && !reduced && (s == img0[4]);
  endfunction

  logic [1:0]  e_src;
  logic [15:0] e_vid, e_pid;
  logic [3:0]  e_fix, e_act;
  logic [2:0]  e_cnt;
  logic [8:0]  e_pwr;
  logic        e_clp;

  task automatic expect_all();
    logic [7:0] t [16];
    if (img_ok(0)) e_src = 2'd0; else if (img_ok(1)) e_src = 2'd1; else e_src = 2'd2;
    if (e_src == 2'd2) begin
      e_vid = 16'h04B4; e_pid = 16'h6570; e_pwr = 9'd100; e_clp = 0;
      e_fix = reduced ? 4'h0 : sfix;
      e_cnt = reduced ? 3'd4 : 3'(4 - int'(ssel));
    end else begin
      for (int i = 0; i < 16; i++) t[i] = (e_src == 2'd0) ? img0[i] : img1[i];
      e_vid = {t[1], t[0]}; e_pid = {t[3], t[2]};
      e_fix = t[6][4:1];
      e_clp = !(t[7] >= 1 && t[7] <= 4);
      e_cnt = e_clp ? 3'd4 : t[7][2:0];
      e_pwr = 9'(int'(t[8]) * 2);
    end
    e_act = 4'((1 << e_cnt) - 1);
  endtask

  task automatic run_case(input bit chk_reset);
    int n;
    logic [63:0] snap;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (chk_reset) begin
      chk("R11 reset done", done, 0);
      chk("R11 reset vid", vid, 0);
      chk("R11 reset count", count, 0);
      chk("R11 reset power", power, 0);
    end
    expect_all();
    rst_n = 1'b1;
    n = 0;
    while (!done && n < 600) begin @(negedge clk); n++; end
    if (!done) begin
      chk("R11 done never rose", 0, 1);
      return;
    end
    chk("R1 src", src, e_src);
    chk("R3 vid", vid, e_vid);
    chk("R3 pid", pid, e_pid);
    chk("R5 fixed", fixed, e_fix);
    chk("R6 count", count, e_cnt);
    chk("R6 active", active, e_act);
    chk("R6 clamped", clamped, e_clp);
    chk("R7 power", power, e_pwr);
    snap = {vid, pid, fixed, active, count, power, clamped, src};
    repeat (5) @(negedge clk);
    chk("R11 done held", done, 1);
    chk("R11 outputs stable", {vid, pid, fixed, active, count, power, clamped, src}, snap);
    chk("R11 single rise", rises, 1);
    chk("R1 order", order_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R11 watchdog expired act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // primary good
    set_img(0, 16'h1234, 16'hABCD, 8'h0A, 8'h03, 8'h64);
    set_img(1, 16'h5555, 16'h6666, 8'h00, 8'h02, 8'h10);
    pres0 = 1; pres1 = 1; lat0 = 1; lat1 = 2;
    run_case(1);
    chk("R3 addresses read", seen0, 16'h01DF);
    chk("R3 read order", dup_bad, 0);
    chk("R1 secondary untouched", req1_ever, 0);

    // primary bad checksum, secondary good
    img0[4] = img0[4] + 8'd1;
    run_case(0);
    chk("R4 fell to secondary", src, 1);
    chk("R3 secondary addresses", seen1, 16'h01DF);

    // both bad: straps
    img1[4] = img1[4] ^ 8'h80; sfix = 4'b1010; ssel = 2'd2;
    run_case(0);
    chk("R8 strap source", src, 2);

    // reduced with both good
    set_img(0, 16'h1111, 16'h2222, 8'h1E, 8'h04, 8'h20);
    set_img(1, 16'h3333, 16'h4444, 8'h04, 8'h01, 8'h30);
    reduced = 1;
    run_case(0);
    chk("R2 rom0 never read", seen0, 0);
    chk("R2 secondary chosen", src, 1);

    // reduced, both bad: straps ignored
    img1[4] = img1[4] + 8'd3; sfix = 4'hF; ssel = 2'd3;
    run_case(0);
    chk("R2 straps ignored fixed", fixed, 0);
    chk("R2 straps ignored count", count, 4);
    reduced = 0;

    // absent primary
    set_img(1, 16'h3333, 16'h4444, 8'h04, 8'h01, 8'h30);
    pres0 = 0;
    run_case(0);
    chk("R9 no request on absent", seen0, 0);
    chk("R9 no rom0 request run", max0, 0);
    chk("R9 secondary chosen", src, 1);

    // silent primary times out
    pres0 = 1; mute0 = 1;
    run_case(0);
    chk("R10 timeout run length", max0, TMO);
    chk("R10 moved to secondary", src, 1);
    mute1 = 1;
    run_case(0);
    chk("R10 both silent -> straps", src, 2);
    chk("R10 secondary run length", max1, TMO);
    mute0 = 0; mute1 = 0; pres1 = 0;

    // checksum sweep (R4)
    for (int v = 0; v < 256; v++) begin
      set_img(0, 16'h04B4, 16'h6570, 8'h00, 8'h02, 8'h40);
      img0[4] = 8'(v);
      lat0 = 1 + (v % 3);
      run_case(0);
    end
    // mask sweep (R5)
    for (int v = 0; v < 256; v++) begin
      set_img(0, 16'(v * 7), 16'(v * 13), 8'(v), 8'h04, 8'h01);
      run_case(0);
    end
    // count sweep (R6)
    for (int v = 0; v < 17; v++) begin
      set_img(0, 16'h0102, 16'h0304, 8'h00, (v == 16) ? 8'hFF : 8'(v), 8'h05);
      run_case(0);
    end
    // power sweep (R7)
    for (int v = 0; v < 256; v++) begin
      set_img(0, 16'hBEEF, 16'hCAFE, 8'h02, 8'h01, 8'(v));
      run_case(0);
    end
    // strap sweep (R8)
    pres0 = 0;
    for (int f = 0; f < 16; f++) begin
      for (int s = 0; s < 4; s++) begin
        sfix = 4'(f); ssel = 2'(s);
        run_case(0);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule